// File: doc/BRIEF.md
# Compare-and-Reload Timer Channel

This block is one timer channel that counts ticks from a choice of two sources: the system clock divided by two, or a programmable prescaler. Software programs a start value, a match value and a handful of control bits through a small register port. Once enabled, the channel clears its count. On its first tick it takes the start value, and after that it adds one on every tick.

When the count lands on the match value, a sticky match flag is raised. In reload mode the channel goes back to the start value on the following tick. Otherwise it runs on and eventually wraps through zero, which raises a sticky wrap flag. Each flag drives a level interrupt output through its own enable bit. The live count and every register can be read back at any moment through a combinational read port.

Top module: `tick_compare_timer`

## Requirements
- R1: Writing the control register (address 0) with the run bit (bit 0) set while it is clear forces the count to 0. While the run bit is clear, the count holds its value.
- R2: On the first tick after the run bit is set, the count takes the start value (address 1). Each later tick adds one to the count.
- R3: When a tick makes the count equal to the match value (address 2), the match flag (status bit 0) is set. cmpIrq equals that flag ANDed with the match interrupt enable (control bit 6).
- R4: With reload mode set (control bit 5), the tick that follows a tick on which the count equals the match value loads the start value again.
- R5: With reload mode clear, the count keeps incrementing past the match value.
- R6: A tick at count 0xFFFFFF wraps the count to 0 and sets the wrap flag (status bit 1). ovfIrq equals that flag ANDed with the wrap interrupt enable (control bit 7).
- R7: With the source select (control bit 8) clear, a tick occurs every 2 clocks and the start value appears 2 clocks after the enabling write. With it set, a tick occurs every P+1 clocks, where P is the prescaler reload (address 3), and the start value appears P+1 clocks after the enabling write.
- R8: The mode field is control bits 4:1, and only the value 0 counts. A write to the mode field is ignored while the run bit is set.
- R9: Address 5 returns the live count. Reading it has no effect on counting.
- R10: Writing a 1 to a status bit (address 4) clears that flag. If the flag is set on the same edge as the clearing write, it stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 24 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 24 | Combinational read data |
| cmpIrq | output | 1 | Match interrupt level |
| ovfIrq | output | 1 | Wrap interrupt level |

## Verification
The count function is driven with four patterns.

- A low match value with reload off shows that the start value loads on the first tick and that counting continues past the match.
- A short reload window of three values shows the reload landing exactly one tick after the match.
- A start value just below all-ones separates the wrap flag from the match flag and exercises interrupt gating with one enable on and the other off.
- A prescaled run with P=3 checks the tick spacing against the divide-by-two source.

Mode writes made while running and while stopped show the difference between an ignored write and one that takes effect. A clearing write timed onto the match edge shows the priority of set over clear.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOAD   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP    = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PRE    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd5;

  localparam int RUN_BIT    = 0;
  localparam int MODE_LSB   = 1;
  localparam int RELOAD_BIT = 5;
  localparam int CIE_BIT    = 6;
  localparam int OIE_BIT    = 7;
  localparam int CSEL_BIT   = 8;

  typedef struct packed {
    logic clr;
    logic load;
    logic inc;
    logic clrCmpFlag;
    logic clrOvfFlag;
  } cntStrobe_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 21,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic [CNT_W-1:0]  count,
  input  logic              atCompare,
  input  logic              cmpFlag,
  input  logic              ovfFlag,
  output cntStrobe_t        strb,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  cmpVal,
  output logic              cmpIe,
  output logic              ovfIe
);
  logic              enReg, reloadMode, clkSel;
  logic [MODE_W-1:0] modeReg;
  logic [CNT_W-1:0]  preReg;
  logic [PRE_W-1:0]  preCnt;
  logic              divPhase, firstPend, running, tick, startEvt, ctrlWr, statWr;

  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign statWr   = wrEn && (wrAddr == ADDR_STATUS);
  assign startEvt = ctrlWr && wrData[RUN_BIT] && !enReg;
  assign running  = enReg && (modeReg == '0);

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= 1'b0; modeReg <= '0; reloadMode <= 1'b0;
      cmpIe <= 1'b0; ovfIe <= 1'b0; clkSel <= 1'b0;
      loadVal <= '0; cmpVal <= '0; preReg <= '0;
    end else if (wrEn) begin
      unique case (wrAddr)
        ADDR_CTRL: begin
          enReg      <= wrData[RUN_BIT];
          if (!enReg) modeReg <= wrData[MODE_LSB +: MODE_W];
          reloadMode <= wrData[RELOAD_BIT];
          cmpIe      <= wrData[CIE_BIT];
          ovfIe      <= wrData[OIE_BIT];
          clkSel     <= wrData[CSEL_BIT];
        end
        ADDR_LOAD: loadVal <= wrData;
        ADDR_CMP:  cmpVal  <= wrData;
        ADDR_PRE:  preReg  <= wrData;
        default: ;
      endcase
    end
  end

  // tick sources
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divPhase <= 1'b0;
      preCnt   <= '0;
    end else if (!running) begin
      divPhase <= 1'b0;
      preCnt   <= preReg[PRE_W-1:0];
    end else begin
      divPhase <= ~divPhase;
      preCnt   <= (preCnt == '0) ? preReg[PRE_W-1:0] : preCnt - 1'b1;
    end
  end

  assign tick = running && (clkSel ? (preCnt == '0) : divPhase);

  always_ff @(posedge clk) begin
    if (!rstN)         firstPend <= 1'b0;
    else if (startEvt) firstPend <= 1'b1;
    else if (tick)     firstPend <= 1'b0;
  end

  always_comb begin
    strb.clr        = startEvt;
    strb.load       = tick && (firstPend || (reloadMode && atCompare));
    strb.inc        = tick && !strb.load;
    strb.clrCmpFlag = statWr && wrData[0];
    strb.clrOvfFlag = statWr && wrData[1];
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL:   rdData = CNT_W'({clkSel, ovfIe, cmpIe, reloadMode, modeReg, enReg});
      ADDR_LOAD:   rdData = loadVal;
      ADDR_CMP:    rdData = cmpVal;
      ADDR_PRE:    rdData = preReg;
      ADDR_STATUS: rdData = CNT_W'({ovfFlag, cmpFlag});
      ADDR_COUNT:  rdData = count;
      default:     rdData = '0;
    endcase
  end

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    enReg |=> $stable(modeReg));

  assert_div2_spacing_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !clkSel && !wrEn) |=> !tick);

  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clr, strb.load, strb.inc}));
endmodule

// File: rtl/tick_timer_datapath.sv
module tick_timer_datapath
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] count,
  output logic             atCompare,
  output logic             cmpFlag,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] nextCount;
  logic             cmpHit, ovfHit;

  always_comb begin
    if (strb.clr)       nextCount = '0;
    else if (strb.load) nextCount = loadVal;
    else if (strb.inc)  nextCount = count + 1'b1;
    else                nextCount = count;
  end

  assign atCompare = (count == cmpVal);
  assign cmpHit    = (strb.load || strb.inc) && (nextCount == cmpVal);
  assign ovfHit    = strb.inc && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      cmpFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      count <= nextCount;
      if (cmpHit)               cmpFlag <= 1'b1;
      else if (strb.clrCmpFlag) cmpFlag <= 1'b0;
      if (ovfHit)               ovfFlag <= 1'b1;
      else if (strb.clrOvfFlag) ovfFlag <= 1'b0;
    end
  end

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clr || strb.load || strb.inc) |=> $stable(count));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && count == CNT_MAX) |=> (count == '0 && ovfFlag));

  assert_cmp_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpFlag) |-> (count == cmpVal));
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 21,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              cmpIrq,
  output logic              ovfIrq
);
  cntStrobe_t       strb;
  logic [CNT_W-1:0] count, loadVal, cmpVal;
  logic             atCompare, cmpFlag, ovfFlag, cmpIe, ovfIe;

  tick_timer_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .MODE_W(MODE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .count(count), .atCompare(atCompare),
    .cmpFlag(cmpFlag), .ovfFlag(ovfFlag), .strb(strb), .loadVal(loadVal),
    .cmpVal(cmpVal), .cmpIe(cmpIe), .ovfIe(ovfIe)
  );

  tick_timer_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal), .cmpVal(cmpVal),
    .count(count), .atCompare(atCompare), .cmpFlag(cmpFlag), .ovfFlag(ovfFlag)
  );

  assign cmpIrq = cmpFlag && cmpIe;
  assign ovfIrq = ovfFlag && ovfIe;
endmodule

// File: tb/sim_tick_compare_timer.sv
`timescale 1ns/100ps
module sim_tick_compare_timer;
  localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_CMP = 3'd2,
                         A_PRE = 3'd3, A_STAT = 3'd4, A_CNT = 3'd5;

  logic        clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0]  wrAddr = '0, rdAddr = '0;
  logic [23:0] wrData = '0;
  logic [23:0] rdData;
  logic        cmpIrq, ovfIrq;
  int          nTests = 0, nFail = 0;
  logic [23:0] v, c0;

  always #2.5 clk = ~clk;

  tick_compare_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cmpIrq(cmpIrq), .ovfIrq(ovfIrq)
  );

  function automatic logic [23:0] ctl(bit en, logic [3:0] mode, bit rl, bit cie, bit oie, bit cs);
    return {15'd0, cs, oie, cie, rl, mode, en};
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge, returns at the negedge after it
  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic stopAndClear();
    wr(A_CTRL, ctl(0, 4'd0, 0, 0, 0, 0));
    wr(A_STAT, 24'h3);
  endtask

  task automatic testReset();
    rd(A_CNT, v);  chk("R1 reset count", v, 24'h0);
    rd(A_STAT, v); chk("R3 reset flags", v, 24'h0);
    chk("R3 reset irqs", {22'd0, cmpIrq, ovfIrq}, 24'h0);
  endtask

  task automatic testBasic();
    wr(A_LOAD, 24'd5); wr(A_CMP, 24'd8);
    wr(A_CTRL, ctl(1, 4'd0, 0, 1, 0, 0));
    rd(A_CNT, v); chk("R1 clear on enable", v, 24'd0);
    @(negedge clk); rd(A_CNT, v); chk("R7 no tick after 1 clk", v, 24'd0);
    @(negedge clk); rd(A_CNT, v); chk("R2 first tick loads", v, 24'd5);
    rd(A_CTRL, v); rd(A_CNT, v); rd(A_CNT, v);
    repeat (2) @(negedge clk); rd(A_CNT, v); chk("R9 R2 increments after reads", v, 24'd6);
    repeat (4) @(negedge clk); rd(A_CNT, v); chk("R3 at compare", v, 24'd8);
    rd(A_STAT, v); chk("R3 match flag set", v, 24'h1);
    chk("R3 cmpIrq level", {23'd0, cmpIrq}, 24'd1);
    repeat (2) @(negedge clk); rd(A_CNT, v); chk("R5 counts past compare", v, 24'd9);
    wr(A_STAT, 24'h1);
    rd(A_STAT, v); chk("R10 flag cleared", v, 24'h0);
    chk("R10 irq drops", {23'd0, cmpIrq}, 24'd0);
    wr(A_CTRL, ctl(0, 4'd0, 0, 1, 0, 0));
    rd(A_CNT, c0);
    repeat (6) @(negedge clk); rd(A_CNT, v); chk("R1 holds while stopped", v, c0);
    stopAndClear();
  endtask

  task automatic testReload();
    wr(A_LOAD, 24'd10); wr(A_CMP, 24'd12);
    wr(A_CTRL, ctl(1, 4'd0, 1, 0, 0, 0));
    for (int k = 0; k < 7; k++) begin
      repeat (2) @(negedge clk);
      rd(A_CNT, v);
      chk($sformatf("R4 reload seq %0d", k), v, 24'd10 + 24'(k % 3));
    end
    rd(A_STAT, v); chk("R4 match flag in reload", v, 24'h1);
    stopAndClear();
  endtask

  task automatic testWrap();
    wr(A_LOAD, 24'hFFFFFE); wr(A_CMP, 24'd3);
    wr(A_CTRL, ctl(1, 4'd0, 0, 0, 1, 0));
    repeat (4) @(negedge clk); rd(A_CNT, v); chk("R6 at max", v, 24'hFFFFFF);
    rd(A_STAT, v); chk("R6 no flag before wrap", v, 24'h0);
    repeat (2) @(negedge clk); rd(A_CNT, v); chk("R6 wrapped", v, 24'h0);
    rd(A_STAT, v); chk("R6 wrap flag", v, 24'h2);
    chk("R6 ovfIrq level", {23'd0, ovfIrq}, 24'd1);
    repeat (6) @(negedge clk); rd(A_CNT, v); chk("R3 reaches compare", v, 24'd3);
    rd(A_STAT, v); chk("R3 both flags", v, 24'h3);
    chk("R3 cmpIrq gated off", {23'd0, cmpIrq}, 24'd0);
    wr(A_CTRL, ctl(0, 4'd0, 0, 0, 0, 0));
    chk("R6 ovfIrq gated off", {23'd0, ovfIrq}, 24'd0);
    stopAndClear();
  endtask

  task automatic testPrescale();
    wr(A_PRE, 24'd3); wr(A_LOAD, 24'd100); wr(A_CMP, 24'd0);
    wr(A_CTRL, ctl(1, 4'd0, 0, 0, 0, 1));
    repeat (3) @(negedge clk); rd(A_CNT, v); chk("R7 prescale before first tick", v, 24'd0);
    @(negedge clk); rd(A_CNT, v); chk("R7 prescale first tick", v, 24'd100);
    repeat (3) @(negedge clk); rd(A_CNT, v); chk("R7 prescale hold", v, 24'd100);
    @(negedge clk); rd(A_CNT, v); chk("R7 prescale second tick", v, 24'd101);
  endtask

  task automatic testMode();
    // still running from testPrescale, one tick per 4 clocks
    wr(A_CTRL, ctl(1, 4'd5, 0, 0, 0, 1));
    rd(A_CTRL, v); chk("R8 mode write ignored while running", v[4:1], 24'd0);
    rd(A_CNT, c0);
    repeat (4) @(negedge clk); rd(A_CNT, v); chk("R8 still counting", v, c0 + 24'd1);
    wr(A_CTRL, ctl(0, 4'd0, 0, 0, 0, 0));
    wr(A_CTRL, ctl(0, 4'd5, 0, 0, 0, 0));
    rd(A_CTRL, v); chk("R8 mode write while stopped", v[4:1], 24'd5);
    wr(A_CTRL, ctl(1, 4'd5, 0, 0, 0, 0));
    repeat (12) @(negedge clk); rd(A_CNT, v); chk("R8 nonzero mode does not count", v, 24'd0);
    wr(A_CTRL, ctl(0, 4'd5, 0, 0, 0, 0));
    wr(A_CTRL, ctl(0, 4'd0, 0, 0, 0, 0));
    stopAndClear();
  endtask

  task automatic testSetBeatsClear();
    wr(A_LOAD, 24'd5); wr(A_CMP, 24'd6);
    wr(A_CTRL, ctl(1, 4'd0, 0, 1, 0, 0));
    repeat (3) @(negedge clk);
    wr(A_STAT, 24'h1);              // lands on the same edge as the match
    rd(A_CNT, v); chk("R10 count at match", v, 24'd6);
    rd(A_STAT, v); chk("R10 set wins over clear", v, 24'h1);
    wr(A_STAT, 24'h1);
    rd(A_STAT, v); chk("R10 later clear works", v, 24'h0);
    stopAndClear();
  endtask

  initial begin
    #100000;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testReload();
    testWrap();
    testPrescale();
    testMode();
    testSetBeatsClear();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule